// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular tracking buffer for a speculative out-of-order core. The front end allocates one slot per instruction in program order and tags the instruction with the slot index it gets back. Execution units later report completion against that index, with a flag for a fault and a flag for a wrong branch guess, plus the physical destination tag of the result. The oldest slot retires once it has completed. Only retirement reaches the rename map and the register file, so architectural state stays precise.

A fault is not acted on when it is reported. It is raised only when the faulting slot becomes the oldest one. At that point the block outputs the faulting PC, retires nothing that cycle and discards every slot. A wrong branch guess works differently. In the cycle it is reported, the block asks for a front-end redirect, and on the next edge it drops every slot younger than the branch. The branch itself stays and retires normally later.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_idx` is 0, and `commit_valid`, `exc_valid` and `flush_valid` are 0.
- R2: Each accepted dispatch (`disp_valid` and `disp_ready` both high at an edge) takes the slot shown on `disp_idx`. Slots are handed out in consecutive index order and wrap from DEPTH-1 to 0.
- R3: Once DEPTH slots are occupied, `disp_ready` is 0 and `disp_valid` has no effect.
- R4: Each cycle at most one slot retires. It is always the oldest one, and only after its completion has been recorded. `commit_idx` and `commit_tag` give that slot and the tag recorded at completion. A younger slot that completed earlier waits its turn.
- R5: A completion report for a slot that is unoccupied or already completed is ignored. In particular, it raises no redirect.
- R6: When the oldest slot has completed with its fault flag set, `exc_valid` is 1, `exc_pc` is that slot's dispatch PC and `commit_valid` is 0. On the next edge all slots are discarded, so the next cycle shows an empty buffer with `disp_idx` 0.
- R7: A completion with the mispredict flag set (fault flag clear) raises `flush_valid` in that same cycle, with `flush_idx` equal to the branch slot. On the next edge all younger slots are discarded and the next dispatch gets branch index + 1. The branch later retires normally, and the discarded slots never retire.
- R8: `disp_ready` is 0 in any cycle in which `exc_valid` or `flush_valid` is 1.
- R9: A retirement from a full buffer frees one slot: in the next cycle `disp_ready` is 1.
- R10: A fault recorded on a slot that is not the oldest raises nothing until every older slot has retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Front end offers an instruction |
| disp_pc | input | PC_W | PC of the offered instruction |
| disp_ready | output | 1 | A slot can be accepted this cycle |
| disp_idx | output | IDX_W | Slot index given to the offered instruction |
| cmpl_valid | input | 1 | Execution unit reports a completion |
| cmpl_idx | input | IDX_W | Slot being completed |
| cmpl_exc | input | 1 | Completed instruction faulted |
| cmpl_mispred | input | 1 | Completed branch was mispredicted |
| cmpl_tag | input | TAG_W | Physical destination tag of the result |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_idx | output | IDX_W | Index of the retiring slot |
| commit_tag | output | TAG_W | Destination tag of the retiring slot |
| exc_valid | output | 1 | Precise fault request |
| exc_pc | output | PC_W | PC of the faulting instruction |
| flush_valid | output | 1 | Redirect request for a mispredicted branch |
| flush_idx | output | IDX_W | Slot of the mispredicted branch |

## Verification
The hardest case to reach is a redirect that leaves slots behind which have been invalidated but whose indices will be reused. The mispredicted branch must still retire, a late completion aimed at a discarded slot must change nothing, and the same branch reported a second time must not redirect again. The stimulus dispatches five instructions and completes the middle branch first, out of order. It then immediately reports that branch again, followed by a completion to a discarded slot, and only then lets the oldest slot finish. Retirement is expected to stop exactly at the branch. The fault path gets similar treatment: a fault is recorded behind an unfinished older slot, so it has to stay silent until that older slot retires.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // per-slot status bits
   typedef struct packed {
      logic valid;
      logic done;
      logic fault;
   } rob_flags_t;

   localparam rob_flags_t ROB_FLAGS_EMPTY = '{valid: 1'b0, done: 1'b0, fault: 1'b0};

endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers with a wrap bit, occupancy and the younger-than-branch kill mask.
module rob_ptrs #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             clear,
   input  logic             flush,
   input  logic [IDX_W-1:0] flush_idx,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic             full,
   output logic [DEPTH-1:0] kill_mask
);
   localparam int PW = IDX_W + 1;

   logic [PW-1:0]    head_q, tail_q, count, tail_after_br;
   logic [IDX_W-1:0] br_dist;

   assign head_idx      = head_q[IDX_W-1:0];
   assign tail_idx      = tail_q[IDX_W-1:0];
   assign count         = tail_q - head_q;
   assign full          = (count == PW'(DEPTH));
   assign br_dist       = flush_idx - head_idx;
   assign tail_after_br = head_q + PW'(br_dist) + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (clear) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + PW'(pop);
         tail_q <= flush ? tail_after_br : tail_q + PW'(push);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_kill
      logic [IDX_W-1:0] age;
      assign age          = IDX_W'(i) - head_idx;
      assign kill_mask[i] = flush && (age > br_dist);
   end
endmodule

// File: rtl/rob_slots.sv
// Slot storage: status flags, dispatch PC and completion tag per slot.
module rob_slots
   import rob_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int PC_W  = 32,
   parameter int TAG_W = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic [DEPTH-1:0]            kill_mask,
   input  logic                        alloc,
   input  logic [IDX_W-1:0]            alloc_idx,
   input  logic [PC_W-1:0]             alloc_pc,
   input  logic                        fin,
   input  logic [IDX_W-1:0]            fin_idx,
   input  logic                        fin_fault,
   input  logic [TAG_W-1:0]            fin_tag,
   input  logic                        retire,
   input  logic [IDX_W-1:0]            retire_idx,
   output rob_flags_t [DEPTH-1:0]      flags,
   output logic [DEPTH-1:0][PC_W-1:0]  pcs,
   output logic [DEPTH-1:0][TAG_W-1:0] tags
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic hit_alloc, hit_fin, hit_retire;
      assign hit_alloc  = alloc  && (alloc_idx  == IDX_W'(i));
      assign hit_fin    = fin    && (fin_idx    == IDX_W'(i));
      assign hit_retire = retire && (retire_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= ROB_FLAGS_EMPTY;
            pcs[i]   <= '0;
            tags[i]  <= '0;
         end else if (clear || kill_mask[i] || hit_retire) begin
            flags[i].valid <= 1'b0;
         end else if (hit_alloc) begin
            flags[i] <= '{valid: 1'b1, done: 1'b0, fault: 1'b0};
            pcs[i]   <= alloc_pc;
         end else if (hit_fin) begin
            flags[i].done  <= 1'b1;
            flags[i].fault <= fin_fault;
            tags[i]        <= fin_tag;
         end
      end
   end
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int  DEPTH = 16,
   parameter int  PC_W  = 32,
   parameter int  TAG_W = 6,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [PC_W-1:0]  disp_pc,
   output logic             disp_ready,
   output logic [IDX_W-1:0] disp_idx,
   input  logic             cmpl_valid,
   input  logic [IDX_W-1:0] cmpl_idx,
   input  logic             cmpl_exc,
   input  logic             cmpl_mispred,
   input  logic [TAG_W-1:0] cmpl_tag,
   output logic             commit_valid,
   output logic [IDX_W-1:0] commit_idx,
   output logic [TAG_W-1:0] commit_tag,
   output logic             exc_valid,
   output logic [PC_W-1:0]  exc_pc,
   output logic             flush_valid,
   output logic [IDX_W-1:0] flush_idx
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_core: DEPTH must be a power of two of at least 2");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("rob_core: PC_W must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("rob_core: TAG_W must be at least 1");
   end

   rob_flags_t [DEPTH-1:0]        flags;
   logic [DEPTH-1:0][PC_W-1:0]    pcs;
   logic [DEPTH-1:0][TAG_W-1:0]   tags;
   logic [DEPTH-1:0]              kill_mask;
   logic [IDX_W-1:0]              head_idx, tail_idx;
   logic                          full, disp_fire, fin_ok;
   rob_flags_t                    head_f, cmpl_f;

   assign head_f = flags[head_idx];
   assign cmpl_f = flags[cmpl_idx];

   assign exc_valid    = head_f.valid && head_f.done && head_f.fault;
   assign commit_valid = head_f.valid && head_f.done && !head_f.fault;
   assign commit_idx   = head_idx;
   assign commit_tag   = tags[head_idx];
   assign exc_pc       = pcs[head_idx];

   assign fin_ok      = cmpl_valid && cmpl_f.valid && !cmpl_f.done && !exc_valid;
   assign flush_valid = fin_ok && cmpl_mispred && !cmpl_exc;
   assign flush_idx   = cmpl_idx;

   assign disp_ready = !full && !exc_valid && !flush_valid;
   assign disp_idx   = tail_idx;
   assign disp_fire  = disp_valid && disp_ready;

   rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (disp_fire),
      .pop       (commit_valid),
      .clear     (exc_valid),
      .flush     (flush_valid),
      .flush_idx (cmpl_idx),
      .head_idx  (head_idx),
      .tail_idx  (tail_idx),
      .full      (full),
      .kill_mask (kill_mask)
   );

   rob_slots #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PC_W(PC_W), .TAG_W(TAG_W)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (exc_valid),
      .kill_mask  (kill_mask),
      .alloc      (disp_fire),
      .alloc_idx  (tail_idx),
      .alloc_pc   (disp_pc),
      .fin        (fin_ok),
      .fin_idx    (cmpl_idx),
      .fin_fault  (cmpl_exc),
      .fin_tag    (cmpl_tag),
      .retire     (commit_valid),
      .retire_idx (head_idx),
      .flags      (flags),
      .pcs        (pcs),
      .tags       (tags)
   );
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_ready,
   input logic [IDX_W-1:0] disp_idx,
   input logic             commit_valid,
   input logic [IDX_W-1:0] commit_idx,
   input logic             exc_valid,
   input logic             flush_valid,
   input logic [IDX_W-1:0] flush_idx
);
   // expected index of the next retirement, kept independently of the pointers
   logic [IDX_W-1:0] exp_head;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            exp_head <= '0;
      else if (exc_valid)    exp_head <= '0;
      else if (commit_valid) exp_head <= exp_head + IDX_W'(1);
   end

   assert_in_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> commit_idx == exp_head);

   assert_fault_blocks_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !commit_valid);

   assert_fault_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (!commit_valid && !exc_valid && disp_idx == '0));

   assert_redirect_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> disp_idx == $past(flush_idx) + IDX_W'(1));

   assert_no_dispatch_on_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid || exc_valid) |-> !disp_ready);
endmodule

bind rob_core rob_checker #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .disp_ready   (disp_ready),
   .disp_idx     (disp_idx),
   .commit_valid (commit_valid),
   .commit_idx   (commit_idx),
   .exc_valid    (exc_valid),
   .flush_valid  (flush_valid),
   .flush_idx    (flush_idx)
);

// File: tb/rob_core_test.sv
`timescale 1ns/1ps
module rob_core_test;
   localparam int DEPTH = 16;
   localparam int PC_W  = 32;
   localparam int TAG_W = 6;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             disp_valid = 1'b0;
   logic [PC_W-1:0]  disp_pc = '0;
   logic             disp_ready;
   logic [IDX_W-1:0] disp_idx;
   logic             cmpl_valid = 1'b0;
   logic [IDX_W-1:0] cmpl_idx = '0;
   logic             cmpl_exc = 1'b0;
   logic             cmpl_mispred = 1'b0;
   logic [TAG_W-1:0] cmpl_tag = '0;
   logic             commit_valid;
   logic [IDX_W-1:0] commit_idx;
   logic [TAG_W-1:0] commit_tag;
   logic             exc_valid;
   logic [PC_W-1:0]  exc_pc;
   logic             flush_valid;
   logic [IDX_W-1:0] flush_idx;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .PC_W(PC_W), .TAG_W(TAG_W)) uut (.*);

   typedef struct packed {
      logic             dv;
      logic             cv;
      logic [IDX_W-1:0] cidx;
      logic [TAG_W-1:0] ctag;
      logic             e_rdy;
      logic [IDX_W-1:0] e_didx;
      logic             e_com;
      logic [IDX_W-1:0] e_cidx;
      logic [TAG_W-1:0] e_ctag;
   } vec_t;

   // per-cycle stimulus with combinational results expected in that cycle
   localparam vec_t VECS [12] = '{
      '{1'b1, 1'b0, 4'd0, 6'd0, 1'b1, 4'd0, 1'b0, 4'd0, 6'd0},
      '{1'b1, 1'b0, 4'd0, 6'd0, 1'b1, 4'd1, 1'b0, 4'd0, 6'd0},
      '{1'b1, 1'b0, 4'd0, 6'd0, 1'b1, 4'd2, 1'b0, 4'd0, 6'd0},
      '{1'b0, 1'b1, 4'd1, 6'd5, 1'b1, 4'd3, 1'b0, 4'd0, 6'd0},
      '{1'b0, 1'b1, 4'd0, 6'd4, 1'b1, 4'd3, 1'b0, 4'd0, 6'd0},
      '{1'b0, 1'b0, 4'd0, 6'd0, 1'b1, 4'd3, 1'b1, 4'd0, 6'd4},
      '{1'b0, 1'b0, 4'd0, 6'd0, 1'b1, 4'd3, 1'b1, 4'd1, 6'd5},
      '{1'b0, 1'b1, 4'd2, 6'd7, 1'b1, 4'd3, 1'b0, 4'd0, 6'd0},
      '{1'b1, 1'b0, 4'd0, 6'd0, 1'b1, 4'd3, 1'b1, 4'd2, 6'd7},
      '{1'b0, 1'b0, 4'd0, 6'd0, 1'b1, 4'd4, 1'b0, 4'd0, 6'd0},
      '{1'b0, 1'b1, 4'd3, 6'd8, 1'b1, 4'd4, 1'b0, 4'd0, 6'd0},
      '{1'b0, 1'b0, 4'd0, 6'd0, 1'b1, 4'd4, 1'b1, 4'd3, 6'd8}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one cycle of inputs at the falling edge, settle, return before the rising edge
   task automatic drive(input logic dv, input logic cv, input logic [IDX_W-1:0] ci,
                        input logic ce, input logic cm, input logic [TAG_W-1:0] ct);
      @(negedge clk);
      disp_valid   = dv;
      disp_pc      = 32'h1000 + 32'(disp_idx) * 4;
      cmpl_valid   = cv;
      cmpl_idx     = ci;
      cmpl_exc     = ce;
      cmpl_mispred = cm;
      cmpl_tag     = ct;
      #1;
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      disp_valid = 1'b0;
      cmpl_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();

      // vector table: in-order retirement with out-of-order completion (R2, R4)
      foreach (VECS[k]) begin
         drive(VECS[k].dv, VECS[k].cv, VECS[k].cidx, 1'b0, 1'b0, VECS[k].ctag);
         chk("R2 disp_ready", 32'(disp_ready), 32'(VECS[k].e_rdy));
         chk("R2 disp_idx", 32'(disp_idx), 32'(VECS[k].e_didx));
         chk("R4 commit_valid", 32'(commit_valid), 32'(VECS[k].e_com));
         if (VECS[k].e_com) begin
            chk("R4 commit_idx", 32'(commit_idx), 32'(VECS[k].e_cidx));
            chk("R4 commit_tag", 32'(commit_tag), 32'(VECS[k].e_ctag));
         end
         chk("R4 no redirect", 32'(flush_valid), 32'd0);
         chk("R4 no fault", 32'(exc_valid), 32'd0);
      end

      // R1: reset state
      do_reset();
      #1;
      chk("R1 disp_ready", 32'(disp_ready), 32'd1);
      chk("R1 disp_idx", 32'(disp_idx), 32'd0);
      chk("R1 commit_valid", 32'(commit_valid), 32'd0);
      chk("R1 exc_valid", 32'(exc_valid), 32'd0);
      chk("R1 flush_valid", 32'(flush_valid), 32'd0);

      // R2/R3/R9: fill, stall, free one slot, wrap
      for (int i = 0; i < DEPTH; i++) begin
         drive(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
         chk("R2 fill ready", 32'(disp_ready), 32'd1);
         chk("R2 fill idx", 32'(disp_idx), 32'(i));
      end
      drive(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      chk("R3 full ready", 32'(disp_ready), 32'd0);
      drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 6'd2);
      chk("R3 full ready held", 32'(disp_ready), 32'd0);
      idle();
      chk("R9 commit from full", 32'(commit_valid), 32'd1);
      chk("R3 ready during commit", 32'(disp_ready), 32'd0);
      drive(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      chk("R9 ready after commit", 32'(disp_ready), 32'd1);
      chk("R2 wrap idx", 32'(disp_idx), 32'd0);
      idle();
      chk("R3 full again", 32'(disp_ready), 32'd0);

      // R10/R6/R8: fault held until head, then precise
      do_reset();
      for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      drive(1'b0, 1'b1, 4'd1, 1'b1, 1'b0, 6'd3);
      chk("R10 fault not yet", 32'(exc_valid), 32'd0);
      idle();
      chk("R10 fault waits", 32'(exc_valid), 32'd0);
      chk("R10 no commit", 32'(commit_valid), 32'd0);
      drive(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 6'd1);
      chk("R10 fault waits older", 32'(exc_valid), 32'd0);
      idle();
      chk("R4 older retires", 32'(commit_valid), 32'd1);
      chk("R10 fault still quiet", 32'(exc_valid), 32'd0);
      drive(1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 6'd4);
      chk("R6 exc_valid", 32'(exc_valid), 32'd1);
      chk("R6 exc_pc", exc_pc, 32'h1004);
      chk("R6 no commit", 32'(commit_valid), 32'd0);
      chk("R8 ready on fault", 32'(disp_ready), 32'd0);
      idle();
      chk("R6 fault cleared", 32'(exc_valid), 32'd0);
      chk("R6 empty commit", 32'(commit_valid), 32'd0);
      chk("R6 empty ready", 32'(disp_ready), 32'd1);
      chk("R6 empty idx", 32'(disp_idx), 32'd0);

      // R7/R5/R8: mispredict squashes younger slots
      do_reset();
      for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
      drive(1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 6'd9);
      chk("R7 flush_valid", 32'(flush_valid), 32'd1);
      chk("R7 flush_idx", 32'(flush_idx), 32'd1);
      chk("R8 ready on redirect", 32'(disp_ready), 32'd0);
      drive(1'b0, 1'b1, 4'd1, 1'b0, 1'b1, 6'd9);
      chk("R5 repeat report ignored", 32'(flush_valid), 32'd0);
      chk("R7 tail after branch", 32'(disp_idx), 32'd2);
      drive(1'b0, 1'b1, 4'd2, 1'b0, 1'b1, 6'd3);
      chk("R5 squashed slot ignored", 32'(flush_valid), 32'd0);
      drive(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 6'd1);
      chk("R4 head not done yet", 32'(commit_valid), 32'd0);
      idle();
      chk("R4 commit oldest", 32'(commit_valid), 32'd1);
      chk("R4 commit oldest idx", 32'(commit_idx), 32'd0);
      chk("R4 commit oldest tag", 32'(commit_tag), 32'd1);
      idle();
      chk("R7 branch retires", 32'(commit_valid), 32'd1);
      chk("R7 branch idx", 32'(commit_idx), 32'd1);
      chk("R7 branch tag", 32'(commit_tag), 32'd9);
      idle();
      chk("R7 squashed never retire", 32'(commit_valid), 32'd0);
      chk("R7 idx reused", 32'(disp_idx), 32'd2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule